// File: doc/BRIEF.md
# Event Pending and Count Channel

This block gathers single-cycle event strobes from a set of sources into a pending-event vector. Alongside the vector it keeps a one-bit channel count. The count tells a consumer that at least one enabled event has arrived since the consumer last read the channel.

A per-bit enable mask decides which events may raise the count. Every strobe still lands in the pending vector, whether or not its bit is enabled.

The consumer has three simple register strobes:
- a mask write, which loads a new enable mask;
- an acknowledge, which clears a chosen set of pending bits;
- a channel read, which drops the count back to zero.

All inputs sampled in one clock cycle form one combined update. The count is raised only by a fresh event, meaning one whose pending bit was clear before that cycle. The event's bit must also be enabled, and the count must be zero at that time.

Top module: `event_count_channel`

## Requirements
- R1: Each asserted bit of `evtStrobe` is set in `pendingOut` one cycle later, whether or not its mask bit is enabled.
- R2: The count goes from 0 to 1 one cycle after a strobe that meets three conditions in the same cycle: the strobe's bit was clear in `pendingOut`, its mask bit is 1, and the count is 0.
- R3: A strobe on a bit that is already set in `pendingOut` does not raise the count.
- R4: A strobe on a bit whose mask bit is 0 does not raise the count, although the bit still becomes pending.
- R5: The count saturates at 1. While the count is 1 and no read occurs, further fresh events leave it at 1.
- R6: An acknowledge (`ackEn`=1) clears the pending bits selected by 1s in `ackMask`, keeps all other pending bits, and leaves the count unchanged.
- R7: A channel read (`cntRead`=1) clears the count on the next cycle. If the count was already 0 and a qualifying event arrives in the same cycle as the read, the count becomes 1. If the count was 1, the read clears it even when a fresh event arrives in that cycle.
- R8: When a bit is strobed and acknowledged in the same cycle, the strobe wins and the bit ends up pending.
- R9: A mask write (`maskWrEn`=1) loads `maskWrData`. The new mask governs count raising from the next cycle on. A strobe in the same cycle as the mask write is judged against the old mask.
- R10: Reset (`rstN`=0) clears the pending vector, the mask and the count.
- R11: `eventWaiting` is high exactly when the count is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtStrobe | input | NUM_EVT | Event strobes, one per source |
| maskWrEn | input | 1 | Load the enable mask |
| maskWrData | input | NUM_EVT | New enable mask, 1 = may raise count |
| ackEn | input | 1 | Apply acknowledge |
| ackMask | input | NUM_EVT | Pending bits to clear on acknowledge |
| cntRead | input | 1 | Consumer read of the channel, clears the count |
| pendingOut | output | NUM_EVT | Pending-event vector |
| countOut | output | 1 | Channel count (0 or 1) |
| eventWaiting | output | 1 | High while the count is nonzero |

## Verification
Several pairs of functions can fall in the same cycle. The pairs that matter most are a strobe with an acknowledge on the same bit, and a fresh event with a channel read.

Directed steps place each pair in one cycle on purpose and judge the outcome against R7 and R8:
- the pending bit must survive the acknowledge;
- the count must end at 1 only when it was 0 before the read.

A strobe in the same cycle as a mask write is also provoked, to show that the old mask applies. Long random runs then mix every strobe type in the same cycles. Each cycle is compared with a cycle-level model inside the bench.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;
  // Strobes that control hands to the datapath each cycle
  typedef struct packed {
    logic maskLoad;
    logic ackApply;
    logic cntSet;
    logic cntClr;
  } ctlStrobes_t;
endpackage

// File: rtl/evt_chan_datapath.sv
module evt_chan_datapath
  import evt_chan_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic [NUM_EVT-1:0] evtStrobe,
  input  logic [NUM_EVT-1:0] maskWrData,
  input  logic [NUM_EVT-1:0] ackMask,
  output logic [NUM_EVT-1:0] pendQ,
  output logic [NUM_EVT-1:0] maskQ,
  output logic               freshAny
);
  logic [NUM_EVT-1:0] freshVec;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    logic clrBit;
    assign clrBit      = ctl.ackApply & ackMask[i];
    // fresh: not pending before this cycle and enabled by the current mask
    assign freshVec[i] = evtStrobe[i] & ~pendQ[i] & maskQ[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[i] <= 1'b0;
      end else if (evtStrobe[i]) begin
        pendQ[i] <= 1'b1;          // a strobe wins over a same-cycle clear
      end else if (clrBit) begin
        pendQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (ctl.maskLoad) begin
      maskQ <= maskWrData;
    end
  end

  assign freshAny = |freshVec;
endmodule

// File: rtl/evt_chan_control.sv
module evt_chan_control
  import evt_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        maskWrEn,
  input  logic        ackEn,
  input  logic        cntRead,
  input  logic        freshAny,
  output ctlStrobes_t ctl,
  output logic        countQ
);
  always_comb begin
    ctl.maskLoad = maskWrEn;
    ctl.ackApply = ackEn;
    ctl.cntSet   = freshAny & ~countQ;
    ctl.cntClr   = cntRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= 1'b0;
    end else if (ctl.cntSet) begin
      countQ <= 1'b1;
    end else if (ctl.cntClr) begin
      countQ <= 1'b0;
    end
  end
endmodule

// File: rtl/event_count_channel.sv
module event_count_channel
  import evt_chan_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtStrobe,
  input  logic               maskWrEn,
  input  logic [NUM_EVT-1:0] maskWrData,
  input  logic               ackEn,
  input  logic [NUM_EVT-1:0] ackMask,
  input  logic               cntRead,
  output logic [NUM_EVT-1:0] pendingOut,
  output logic               countOut,
  output logic               eventWaiting
);
  ctlStrobes_t        ctl;
  logic               freshAny;
  logic [NUM_EVT-1:0] maskVal;

  evt_chan_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .maskWrEn (maskWrEn),
    .ackEn    (ackEn),
    .cntRead  (cntRead),
    .freshAny (freshAny),
    .ctl      (ctl),
    .countQ   (countOut)
  );

  evt_chan_datapath #(.NUM_EVT(NUM_EVT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .evtStrobe  (evtStrobe),
    .maskWrData (maskWrData),
    .ackMask    (ackMask),
    .pendQ      (pendingOut),
    .maskQ      (maskVal),
    .freshAny   (freshAny)
  );

  assign eventWaiting = countOut;
endmodule

// File: rtl/evt_chan_checker.sv
module evt_chan_checker #(
  parameter int NUM_EVT = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtStrobe,
  input logic               ackEn,
  input logic [NUM_EVT-1:0] ackMask,
  input logic               cntRead,
  input logic [NUM_EVT-1:0] pendingOut,
  input logic [NUM_EVT-1:0] maskVal,
  input logic               countOut,
  input logic               eventWaiting
);
  AST_PEND_ACCUM: assert property (@(posedge clk) disable iff (!rstN)
    (|evtStrobe) |=> ((pendingOut & $past(evtStrobe)) == $past(evtStrobe))); // R1

  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (!countOut && !(|(evtStrobe & ~pendingOut & maskVal))) |=> !countOut); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (countOut && !cntRead) |=> countOut); // R5

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ackEn |=> ((pendingOut & $past(ackMask & ~evtStrobe)) == '0)); // R6

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cntRead && countOut) |=> !countOut); // R7

  AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    eventWaiting == countOut); // R11
endmodule

bind event_count_channel evt_chan_checker #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .evtStrobe    (evtStrobe),
  .ackEn        (ackEn),
  .ackMask      (ackMask),
  .cntRead      (cntRead),
  .pendingOut   (pendingOut),
  .maskVal      (maskVal),
  .countOut     (countOut),
  .eventWaiting (eventWaiting)
);

// File: tb/event_count_channel_test.sv
module event_count_channel_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] evtStrobe, maskWrData, ackMask;
  logic         maskWrEn, ackEn, cntRead;
  logic [N-1:0] pendingOut;
  logic         countOut, eventWaiting;

  int errors = 0;
  int checks = 0;

  // bench model state
  logic [N-1:0] mPend, mMask;
  logic         mCnt;

  event_count_channel #(.NUM_EVT(N)) uut (.*);

  always #5 clk = ~clk;

  function automatic logic nextCnt(logic cnt, logic [N-1:0] pend, logic [N-1:0] msk,
                                   logic [N-1:0] stb, logic rd);
    if (!cnt && |(stb & ~pend & msk)) return 1'b1;
    if (rd) return 1'b0;
    return cnt;
  endfunction

  function automatic logic [N-1:0] nextPend(logic [N-1:0] pend, logic [N-1:0] stb,
                                            logic ack, logic [N-1:0] am);
    return (pend & ~(ack ? am : '0)) | stb;
  endfunction

  task automatic cmp(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expectAll(string tagP, string tagC);
    cmp(tagP, pendingOut, mPend);
    cmp(tagC, {{(N-1){1'b0}}, countOut}, {{(N-1){1'b0}}, mCnt});
    cmp("R11", {{(N-1){1'b0}}, eventWaiting}, {{(N-1){1'b0}}, mCnt});
  endtask

  // drive at negedge, clock once, update model, sample 1 ns after the edge
  task automatic step(logic [N-1:0] stb, logic mwe, logic [N-1:0] md,
                      logic ack, logic [N-1:0] am, logic rd);
    @(negedge clk);
    evtStrobe = stb; maskWrEn = mwe; maskWrData = md;
    ackEn = ack; ackMask = am; cntRead = rd;
    @(posedge clk);
    mCnt  = nextCnt(mCnt, mPend, mMask, stb, rd);
    mPend = nextPend(mPend, stb, ack, am);
    if (mwe) mMask = md;
    #1;
    evtStrobe = '0; maskWrEn = 0; ackEn = 0; cntRead = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    @(posedge clk); @(posedge clk);
    #1;
    mPend = '0; mMask = '0; mCnt = 0;
    rstN = 1;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    evtStrobe = '0; maskWrData = '0; ackMask = '0;
    maskWrEn = 0; ackEn = 0; cntRead = 0; rstN = 0;
    doReset();
    expectAll("R10", "R10");

    // R9: strobe with mask write in same cycle uses old (zero) mask
    step(8'h01, 1, 8'h0F, 0, '0, 0);   expectAll("R1", "R9");
    step('0, 0, '0, 1, 8'h01, 0);      expectAll("R6", "R6");
    step(8'h01, 0, '0, 0, '0, 0);      expectAll("R1", "R2");
    step('0, 0, '0, 0, '0, 1);         expectAll("R1", "R7");
    // R4: masked bit pends, no count
    step(8'h80, 0, '0, 0, '0, 0);      expectAll("R4", "R4");
    // R3: bit0 already pending
    step(8'h01, 0, '0, 0, '0, 0);      expectAll("R3", "R3");
    // R5: saturation
    step(8'h02, 0, '0, 0, '0, 0);      expectAll("R1", "R5");
    step(8'h04, 0, '0, 0, '0, 0);      expectAll("R1", "R5");
    // R6: ack keeps count
    step('0, 0, '0, 1, 8'h03, 0);      expectAll("R6", "R6");
    // R7: read with count 1 and fresh event -> 0
    step(8'h01, 0, '0, 0, '0, 1);      expectAll("R1", "R7");
    // R7: read with count 0 and fresh event -> 1
    step(8'h02, 0, '0, 0, '0, 1);      expectAll("R1", "R7");
    // R8: strobe and ack on same bit
    step(8'h04, 0, '0, 1, 8'h04, 0);   expectAll("R8", "R2");

    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] s, a, m;
      s = N'($urandom) & N'($urandom) & N'($urandom);
      a = N'($urandom);
      m = N'($urandom);
      step(s, ($urandom % 16) == 0, m, ($urandom % 4) == 0, a, ($urandom % 3) == 0);
      expectAll("R1", "R2");
    end

    step(8'hFF, 1, 8'hFF, 0, '0, 0);
    doReset();
    expectAll("R10", "R10");
    step(8'h10, 0, '0, 0, '0, 0);      expectAll("R10", "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule